// File: doc/BRIEF.md
# Reset Conditioner with Filtered Assertion and Synchronized Release

This unit sits at the root of a reset tree. It takes a raw active-low reset, which may come from a pin or from internal logic, and produces one clean active-low reset for every flop in the same clock domain. Before a low level on the raw input counts as a reset, it must be seen on several consecutive clock edges. Once that count is reached, the output reset drops at once, in the same edge. It then stays low whether or not the clock keeps running. Release always passes through a short chain of flops clocked by the receivers' own clock, so all receivers leave reset on the same edge.

A test-mode input holds the output reset inactive. This lets a tester apply vectors even when the raw reset is generated internally and cannot be controlled. The unit also gates a functional tri-state output enable. The enable is removed the instant the raw reset goes low, with no clock needed, and stays off until the synchronized release has finished.

Top module: `rst_conditioner`

## Requirements
- R1: A low level on `rst_n_raw` that is sampled low on fewer than FILTER_LEN (default 4) consecutive rising edges of `clk` leaves `rst_n_sync` at 1.
- R2: When `rst_n_raw` is sampled low on FILTER_LEN consecutive rising edges, `rst_n_sync` goes to 0 on the last of those edges, with no further clock latency.
- R3: Once `rst_n_sync` is 0, it stays 0 while `rst_n_raw` stays low, including when `clk` is stopped.
- R4: After `rst_n_raw` returns to 1, `rst_n_sync` stays 0 through the first rising edge and becomes 1 on the second rising edge (SYNC_STAGES, default 2).
- R5: While `test_mode` is 1, `rst_n_sync` is 1 regardless of `rst_n_raw` and of the clock. When `test_mode` returns to 0 while a reset is still qualified, `rst_n_sync` is 0 again.
- R6: While `test_mode` is 0 and `rst_n_raw` is 0, `oe_safe` is 0, immediately and with no clock edge. This includes glitches too short to qualify.
- R7: Otherwise `oe_safe` equals `func_oe` AND `rst_n_sync`, so it stays 0 until the release has propagated.
- R8: Any rising edge of `rst_n_raw` restarts the low-level count. A low run broken by a high level must again be sampled FILTER_LEN times before it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the receiving flops; also clocks the filter and release chain |
| rst_n_raw | input | 1 | Unfiltered active-low reset request |
| test_mode | input | 1 | 1 holds the output reset inactive for vector application |
| func_oe | input | 1 | Functional tri-state output enable from the core |
| rst_n_sync | output | 1 | Conditioned active-low reset for the tree |
| oe_safe | output | 1 | Tri-state enable, forced off during reset |

## Verification
The bench builds the unit with its defaults: a filter length of 4 and a two-flop release chain. Both boundaries are therefore a few edges away. A run of three low samples can be shown to be rejected and a run of four to be accepted on the fourth edge. The two-edge release can be pinned to exact negative-edge sampling points. With the short chain, a clock-stopped phase can be inserted in the middle of a reset, and the release can be checked straight after the clock resumes.

// File: rtl/rst_conditioner.sv
module rst_conditioner #(
  parameter int FILTER_LEN  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_raw,
  input  logic test_mode,
  input  logic func_oe,
  output logic rst_n_sync,
  output logic oe_safe
);

  localparam int CW = $clog2(FILTER_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILTER_LEN - 1);

  logic [CW-1:0]          low_cnt;
  logic                   qual;
  logic [SYNC_STAGES-1:0] chain;

  // Low-level qualifier: any high level on the raw input clears it at once.
  always_ff @(posedge clk or posedge rst_n_raw) begin
    if (rst_n_raw) begin
      low_cnt <= '0;
      qual    <= 1'b0;
    end else begin
      if (low_cnt != LAST) low_cnt <= low_cnt + 1'b1;
      if (low_cnt == LAST) qual <= 1'b1;
    end
  end

  // Release chain: cleared asynchronously by the qualified reset.
  always_ff @(posedge clk or posedge qual) begin
    if (qual) chain <= '0;
    else      chain <= {chain[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = test_mode | chain[SYNC_STAGES-1];
  assign oe_safe    = func_oe & rst_n_sync & (rst_n_raw | test_mode);

  // R2
  hold_low_chk: assert property (@(posedge clk) disable iff ($isunknown({qual, chain}))
    (qual && !test_mode) |-> !rst_n_sync);

  // R4
  release_two_edge_chk: assert property (@(posedge clk) disable iff ($isunknown({qual, chain}))
    ($rose(rst_n_sync) && !test_mode && $past(!test_mode)) |-> (!qual && $past(!qual)));

  // R1
  qual_needs_run_chk: assert property (@(posedge clk) disable iff ($isunknown({qual, chain}))
    ((FILTER_LEN > 1) && $rose(qual)) |-> $past(!rst_n_raw));

  // R5
  test_bypass_chk: assert property (@(posedge clk) disable iff ($isunknown({qual, chain}))
    test_mode |-> rst_n_sync);

  // R6
  oe_forced_off_chk: assert property (@(posedge clk) disable iff ($isunknown({qual, chain}))
    (!rst_n_raw && !test_mode) |-> !oe_safe);

endmodule

// File: tb/sim_rst_conditioner.sv
module sim_rst_conditioner;
  localparam int CLK_P = 10;

  logic clk = 1'b0, run = 1'b1;
  logic rst_n_raw, test_mode, func_oe;
  logic rst_n_sync, oe_safe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  rst_conditioner u0 (.clk(clk), .rst_n_raw(rst_n_raw), .test_mode(test_mode),
                      .func_oe(func_oe), .rst_n_sync(rst_n_sync), .oe_safe(oe_safe));

  always #(CLK_P/2) clk = run ? ~clk : 1'b0;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_power_up;
    edges(3);
    chk("R2 no reset before fourth low sample (oe)", oe_safe, 1'b0);
    @(posedge clk); #1;
    chk("R2 asserted on fourth edge", rst_n_sync, 1'b0);
    chk("R7 oe off in reset", oe_safe, 1'b0);
  endtask

  task automatic t_release;
    @(negedge clk); rst_n_raw = 1'b1; #1;
    chk("R4 still low right after raw rise", rst_n_sync, 1'b0);
    edges(1);
    chk("R4 low after first edge", rst_n_sync, 1'b0);
    chk("R7 oe off while release propagates", oe_safe, 1'b0);
    edges(1);
    chk("R4 high after second edge", rst_n_sync, 1'b1);
    chk("R7 oe follows func_oe", oe_safe, 1'b1);
    func_oe = 1'b0; #1;
    chk("R7 oe follows func_oe low", oe_safe, 1'b0);
    func_oe = 1'b1;
  endtask

  task automatic t_glitches;
    @(negedge clk); #1; rst_n_raw = 1'b0; #2;
    chk("R6 oe off during short glitch", oe_safe, 1'b0);
    rst_n_raw = 1'b1; edges(2);
    chk("R1 sub-cycle glitch ignored", rst_n_sync, 1'b1);
    chk("R6 oe back after glitch", oe_safe, 1'b1);
    rst_n_raw = 1'b0; edges(1); rst_n_raw = 1'b1; edges(3);
    chk("R1 single-sample glitch ignored", rst_n_sync, 1'b1);
    rst_n_raw = 1'b0; edges(3); rst_n_raw = 1'b1; edges(3);
    chk("R1 three-sample pulse ignored", rst_n_sync, 1'b1);
    rst_n_raw = 1'b0; edges(2); rst_n_raw = 1'b1; edges(1);
    rst_n_raw = 1'b0; edges(3);
    chk("R8 broken run restarts count", rst_n_sync, 1'b1);
    edges(1);
    chk("R8 fourth sample of new run asserts", rst_n_sync, 1'b0);
    rst_n_raw = 1'b1; edges(2);
    chk("R4 release after broken-run test", rst_n_sync, 1'b1);
  endtask

  task automatic t_clock_stopped;
    @(negedge clk); run = 1'b0; #(CLK_P);
    rst_n_raw = 1'b0; #1;
    chk("R6 oe off with clock stopped", oe_safe, 1'b0);
    #(CLK_P*3);
    chk("R1 no qualification without edges", rst_n_sync, 1'b1);
    run = 1'b1; edges(4);
    chk("R2 qualified once clock resumes", rst_n_sync, 1'b0);
    run = 1'b0; #(CLK_P*5);
    chk("R3 held with clock stopped", rst_n_sync, 1'b0);
    chk("R3 oe held off with clock stopped", oe_safe, 1'b0);
    run = 1'b1; edges(2);
    chk("R3 held after clock resumes", rst_n_sync, 1'b0);
  endtask

  task automatic t_test_mode;
    test_mode = 1'b1; #1;
    chk("R5 test mode forces inactive", rst_n_sync, 1'b1);
    chk("R5 oe follows func_oe in test mode", oe_safe, 1'b1);
    edges(3);
    chk("R5 stays inactive across edges", rst_n_sync, 1'b1);
    test_mode = 1'b0; #1;
    chk("R5 qualified reset back after test mode", rst_n_sync, 1'b0);
    rst_n_raw = 1'b1; edges(2);
    chk("R4 final release", rst_n_sync, 1'b1);
  endtask

  initial begin
    rst_n_raw = 1'b1; test_mode = 1'b0; func_oe = 1'b1;
    #2 rst_n_raw = 1'b0;
    t_power_up();
    t_release();
    t_glitches();
    t_clock_stopped();
    t_test_mode();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule